// File: doc/BRIEF.md
# Eight-Bit Multiplexed GPIO Port with Edge Interrupts

This block is one general-purpose I/O port. It has eight pins and identical logic behind each pin. Software reaches a set of per-pin control registers over a plain register bus. For each pin it can drive an output value and an output enable, read back the synchronized pin level, and hand the pad over to a peripheral. When a pin is handed over, the peripheral's own output value and direction drive the pad. The peripheral reads the pin through a level latch that the select bit opens. The latch is transparent while the pin is selected and keeps the last pin value once the select is cleared.

Each pin also has an edge detector with its own edge polarity, sticky flag and enable. Detection runs on a two-stage synchronized copy of the pad input. A selected pin never raises its flag. The enabled flags of all pins are merged into a single interrupt request line. The register bus has no handshake: a write takes effect on the clock edge where it is presented, and read data is combinational. The pad and peripheral signals are level signals, so valid/ready does not apply to them.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset, the output, direction, select, edge-polarity, enable and flag registers all read 0. pad_oe is 0 and irq is 0.
- R2: The register offsets on bus_addr are: 0 pin input (read-only), 1 output value, 2 direction, 3 function select, 4 edge polarity, 5 interrupt enable, 6 interrupt flag. A write with bus_en=1 and bus_we=1 updates the addressed register at the clock edge. bus_rdata shows the addressed register while bus_en=1 and bus_we=0. It shows 0 at offset 7 and whenever no read is presented.
- R3: pad_out bit i equals per_out bit i when select bit i is 1, and output-register bit i when select bit i is 0.
- R4: pad_oe bit i equals per_oe bit i when select bit i is 1, and direction-register bit i when select bit i is 0.
- R5: While select bit i is 1, per_in bit i follows pad_in bit i.
- R6: After select bit i is cleared, per_in bit i holds the pin value from just before the clear, until select bit i is set again.
- R7: Polarity bit 0 makes a rising edge set the flag, and polarity bit 1 makes a falling edge set it. The flag is set two clock edges after the sampling edge that first captures the new pad level, and it stays set until software writes it.
- R8: While select bit i is 1, no pin activity sets flag bit i.
- R9: A write to the flag register loads the written value, so it can both set and clear flag bits. Such a write wins over an edge detected in the same cycle.
- R10: irq is 1 exactly when some flag bit and the matching enable bit are both 1.
- R11: The pin-input register reads the pad level captured two clock edges earlier, whatever the select and direction settings are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pad_in | input | 8 | Level seen at the pins |
| pad_out | output | 8 | Value driven to the pins |
| pad_oe | output | 8 | Pin output enables |
| per_out | input | 8 | Peripheral output values |
| per_oe | input | 8 | Peripheral direction, 1 = drive |
| per_in | output | 8 | Latched pin values for the peripheral |
| irq | output | 1 | Merged interrupt request |

## Verification
The output multiplexer is driven with select masks that split the port into nibbles, so a swapped mux arm or a wrong bit mapping shows up on only half of the pins. The edge detector is given rising and falling transitions on pins with mixed polarity settings. This separates polarity handling from plain level detection. Selected pins are toggled to confirm the interrupt is blocked. A flag write is placed in the exact cycle that a hardware edge lands, to confirm the write wins. The latch is tested by clearing the select and then changing the pin. This separates a hold latch from a transparent wire.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_PIN  = 3'd0,
    REG_OUT  = 3'd1,
    REG_DIR  = 3'd2,
    REG_SEL  = 3'd3,
    REG_POL  = 3'd4,
    REG_IEN  = 3'd5,
    REG_FLAG = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_ctl_regs.sv
module gpio_ctl_regs
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pin_sync,
  input  logic [W-1:0]      flag_q,
  output logic [W-1:0]      out_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      sel_q,
  output logic [W-1:0]      pol_q,
  output logic [W-1:0]      ien_q,
  output logic              flag_we
);
  logic      wr, rd;
  reg_addr_e addr;

  assign addr    = reg_addr_e'(bus_addr);
  assign wr      = bus_en & bus_we;
  assign rd      = bus_en & ~bus_we;
  assign flag_we = wr && (addr == REG_FLAG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
      sel_q <= '0;
      pol_q <= '0;
      ien_q <= '0;
    end else if (wr) begin
      case (addr)
        REG_OUT: out_q <= bus_wdata;
        REG_DIR: dir_q <= bus_wdata;
        REG_SEL: sel_q <= bus_wdata;
        REG_POL: pol_q <= bus_wdata;
        REG_IEN: ien_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (addr)
        REG_PIN:  bus_rdata = pin_sync;
        REG_OUT:  bus_rdata = out_q;
        REG_DIR:  bus_rdata = dir_q;
        REG_SEL:  bus_rdata = sel_q;
        REG_POL:  bus_rdata = pol_q;
        REG_IEN:  bus_rdata = ien_q;
        REG_FLAG: bus_rdata = flag_q;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_sync,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] sel,
  input  logic [W-1:0] ien,
  input  logic         flag_we,
  input  logic [W-1:0] flag_wdata,
  output logic [W-1:0] flag_q,
  output logic         irq
);
  logic [W-1:0] prev_q;
  logic [W-1:0] hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin_sync;
  end

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      logic up, down;
      assign up     = pin_sync[i] & ~prev_q[i];
      assign down   = ~pin_sync[i] & prev_q[i];
      assign hit[i] = ~sel[i] & (pol[i] ? down : up);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= '0;
    else if (flag_we) flag_q <= flag_wdata;
    else              flag_q <= flag_q | hit;
  end

  assign irq = |(flag_q & ien);

  // R9
  flag_wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> (flag_q == $past(flag_wdata)));

  // R8
  sel_blocks_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> ((flag_q & ~$past(flag_q) & $past(sel)) == '0));

  // R7
  flag_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> ((flag_q & ~$past(flag_q) & ~$past(hit)) == '0));
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int W = 8
) (
  input  logic         rst_n,
  input  logic [W-1:0] out_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] sel_q,
  input  logic [W-1:0] per_out,
  input  logic [W-1:0] per_oe,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] per_in
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_mux
      assign pad_out[i] = sel_q[i] ? per_out[i] : out_q[i];
      assign pad_oe[i]  = sel_q[i] ? per_oe[i]  : dir_q[i];
    end
  endgenerate

  always_latch begin
    for (int i = 0; i < W; i++) begin
      if (!rst_n)        per_in[i] <= 1'b0;
      else if (sel_q[i]) per_in[i] <= pad_in[i];
    end
  end
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_port_pkg::*;
#(
  parameter int W        = 8,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe,
  input  logic [W-1:0]      per_out,
  input  logic [W-1:0]      per_oe,
  output logic [W-1:0]      per_in,
  output logic              irq
);
  logic [W-1:0] pin_sync, flag_q;
  logic [W-1:0] out_q, dir_q, sel_q, pol_q, ien_q;
  logic         flag_we;

  gpio_in_sync #(.W(W), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
  );

  gpio_ctl_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_sync(pin_sync), .flag_q(flag_q), .out_q(out_q), .dir_q(dir_q),
    .sel_q(sel_q), .pol_q(pol_q), .ien_q(ien_q), .flag_we(flag_we)
  );

  gpio_edge_irq #(.W(W)) u_irq (
    .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .pol(pol_q), .sel(sel_q),
    .ien(ien_q), .flag_we(flag_we), .flag_wdata(bus_wdata),
    .flag_q(flag_q), .irq(irq)
  );

  gpio_pad_mux #(.W(W)) u_mux (
    .rst_n(rst_n), .out_q(out_q), .dir_q(dir_q), .sel_q(sel_q),
    .per_out(per_out), .per_oe(per_oe), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .per_in(per_in)
  );

  // R6
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((per_in ^ $past(per_in)) & ~sel_q & ~$past(sel_q)) == '0);
endmodule

// File: tb/gpio_mux_port_tb.sv
`timescale 1ns/1ps
module gpio_mux_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_en = 1'b0, bus_we = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'h00, bus_rdata;
  logic [7:0] pad_in = 8'h00, pad_out, pad_oe;
  logic [7:0] per_out = 8'h00, per_oe = 8'h00, per_in;
  logic       irq;

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;

  // behavioural model state
  logic [7:0] m_out, m_dir, m_sel, m_pol, m_ien, m_flag, m_lat;
  logic [7:0] m_s1, m_s2, m_s3;

  always #2.5 clk = ~clk;

  gpio_mux_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .per_out(per_out), .per_oe(per_oe), .per_in(per_in), .irq(irq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [7:0] m_read();
    if (!(bus_en && !bus_we)) return 8'h00;
    case (bus_addr)
      3'd0: return m_s2;
      3'd1: return m_out;
      3'd2: return m_dir;
      3'd3: return m_sel;
      3'd4: return m_pol;
      3'd5: return m_ien;
      3'd6: return m_flag;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_step();
    logic [7:0] hit;
    if (!rst_n) begin
      {m_out, m_dir, m_sel, m_pol, m_ien, m_flag, m_lat} = '0;
      {m_s1, m_s2, m_s3} = '0;
      return;
    end
    hit = ((~m_pol & m_s2 & ~m_s3) | (m_pol & ~m_s2 & m_s3)) & ~m_sel;
    m_lat = (m_lat & ~m_sel) | (pad_in & m_sel);
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = pad_in;
    if (bus_en && bus_we && bus_addr == 3'd6) m_flag = bus_wdata;
    else m_flag = m_flag | hit;
    if (bus_en && bus_we) begin
      case (bus_addr)
        3'd1: m_out = bus_wdata;
        3'd2: m_dir = bus_wdata;
        3'd3: m_sel = bus_wdata;
        3'd4: m_pol = bus_wdata;
        3'd5: m_ien = bus_wdata;
        default: ;
      endcase
    end
  endtask

  task automatic compare();
    chk("R3 pad_out", pad_out, (m_sel & per_out) | (~m_sel & m_out));
    chk("R4 pad_oe", pad_oe, (m_sel & per_oe) | (~m_sel & m_dir));
    chk("R5 R6 per_in", per_in, (m_sel & pad_in) | (~m_sel & m_lat));
    chk("R10 irq", {7'd0, irq}, {7'd0, |(m_flag & m_ien)});
    chk("R2 rdata", bus_rdata, m_read());
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    cyc++;
    @(negedge clk);
    compare();
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_en = 0; bus_we = 0; bus_addr = 3'd0; bus_wdata = 8'h00;
  endtask

  task automatic rd(logic [2:0] a, logic [7:0] exp, string req);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
    bus_en = 0; bus_addr = 3'd0;
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  // watchdog
  always @(posedge clk) begin
    if (!done && cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    ticks(3);
    // R1 reset state
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    tick();
    for (int a = 1; a < 7; a++) rd(3'(a), 8'h00, "R1 reg");
    rd(3'd7, 8'h00, "R2 unused offset");

    // R3 R4 plain I/O
    wr(3'd1, 8'hA5);
    wr(3'd2, 8'hF0);
    chk("R3 out", pad_out, 8'hA5);
    chk("R4 dir", pad_oe, 8'hF0);
    rd(3'd1, 8'hA5, "R2 out readback");

    // peripheral on low nibble
    per_out = 8'h3C; per_oe = 8'h0F;
    wr(3'd3, 8'h0F);
    chk("R3 mixed", pad_out, 8'hAC);
    chk("R4 mixed", pad_oe, 8'hFF);

    // R5 R6 latch
    pad_in = 8'h55;
    tick();
    chk("R5 transparent", per_in & 8'h0F, 8'h05);
    wr(3'd3, 8'h00);
    pad_in = 8'hAA;
    ticks(3);
    chk("R6 hold", per_in & 8'h0F, 8'h05);
    // R11 input reads pin regardless of select/direction
    wr(3'd3, 8'hC3);
    pad_in = 8'h96;
    ticks(2);
    rd(3'd0, 8'h96, "R11 pin read");
    wr(3'd3, 8'h00);

    // R7 polarity: low nibble falling, high nibble rising
    pad_in = 8'h00; ticks(3);
    wr(3'd6, 8'h00);
    wr(3'd4, 8'h0F);
    wr(3'd5, 8'hFF);
    pad_in = 8'hFF; ticks(3);
    rd(3'd6, 8'hF0, "R7 rising");
    pad_in = 8'h00; ticks(3);
    rd(3'd6, 8'hFF, "R7 falling");
    chk("R10 irq set", {7'd0, irq}, 8'h01);

    // R9 software write set/clear, R10 enable mask
    wr(3'd6, 8'h00);
    chk("R9 clear irq", {7'd0, irq}, 8'h00);
    wr(3'd5, 8'h02);
    wr(3'd6, 8'h01);
    chk("R10 masked", {7'd0, irq}, 8'h00);
    wr(3'd5, 8'h01);
    chk("R10 enabled", {7'd0, irq}, 8'h01);
    wr(3'd6, 8'h00);

    // R8 selected pins never flag
    wr(3'd4, 8'h00);
    wr(3'd3, 8'hFF);
    pad_in = 8'hFF; ticks(3);
    pad_in = 8'h00; ticks(3);
    rd(3'd6, 8'h00, "R8 blocked");
    wr(3'd3, 8'h00);
    ticks(3);

    // R9 write wins over same-cycle edge
    pad_in = 8'hFF;
    tick(); tick();
    wr(3'd6, 8'h00);
    rd(3'd6, 8'h00, "R9 priority");
    tick();
    rd(3'd6, 8'h00, "R9 no late set");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule